// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block is a multi-cycle integer divider for a processor datapath. It divides a 32-bit or a 16-bit dividend by a 16-bit divisor, in either unsigned or two's-complement signed arithmetic. It returns a 16-bit quotient and a 16-bit remainder. Internally it works on magnitudes. It forms the quotient one bit per cycle with the non-restoring method, adds the divisor back to a negative final partial remainder, and then applies the result signs.

Every divide takes exactly 19 active cycles. The cycle in which the request is accepted is the first of them, followed by sixteen quotient-bit steps, one remainder-correction cycle and one sign-fixup cycle. A stall input freezes every register, so surrounding control logic (for example an interrupt controller) can suspend the operation at any cycle boundary and resume it later with no loss of progress. Stalled cycles do not count toward the 19. A divisor of zero, or a quotient that does not fit its 16-bit result, sets an overflow flag instead of producing a meaningful result.

Top module: `iter_divider`

## Requirements
- R1: With the block idle and `stall` low, a high `start` is accepted in that cycle and the operands on the inputs are captured. `busy` is high from the next cycle through the cycle in which `done` is high.
- R2: With `is_signed`=0, `quotient` is the floor of N/D and `remainder` is N mod D. N is the full `dividend` when `wide`=1, and `dividend[15:0]` zero-extended when `wide`=0. D is `divisor`.
- R3: With `is_signed`=1, both operands are two's complement and the quotient is truncated toward zero. The remainder carries the sign of the dividend (a zero remainder is 0). When `wide`=0 the dividend is `dividend[15:0]` sign-extended.
- R4: `done` is high for exactly one cycle: the 19th non-stalled cycle, counting the accepting cycle as the first.
- R5: While `stall` is high all internal state holds, the stalled cycle does not count toward the 19, and `done` stays low.
- R6: In the `done` cycle, `ovf` is 1 exactly when the divisor is zero, or when the true quotient falls outside 0..65535 (unsigned) or -32768..32767 (signed). When `ovf` is 1, `quotient` and `remainder` are undefined.
- R7: A `start` raised while `busy` is high is ignored. The running divide completes with its original operands and original cycle count.
- R8: After `done`, `quotient`, `remainder` and `ovf` keep their values until the next accepted `start`.
- R9: During and directly after reset, `busy`, `done` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide (accepted when idle and not stalled) |
| stall | input | 1 | Freeze all state for this cycle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| wide | input | 1 | 1 = 32-bit dividend, 0 = dividend taken from bits 15:0 |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ovf | output | 1 | Zero divisor or quotient out of range |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |

## Verification
Results are due in the 19th non-stalled cycle counted from the accepting cycle. The bench drives inputs on falling edges and samples just after them, keeping its own count of the non-stalled cycles and requiring `done` exactly when that count reaches 19. It checks quotient, remainder and overflow in that cycle against integer arithmetic computed in the bench, and checks one cycle later that the results are still held. Random stall patterns, including stalls on the final cycle and a start raised during a running divide, test that stalls and repeated starts shift the result only by the stalled cycles.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STEP = 2'd1,
    PH_CORR = 2'd2,
    PH_FIX  = 2'd3
  } div_phase_e;
endpackage

// File: rtl/iter_div_prep.sv
// Operand conditioning: width extension, magnitudes, result signs and the
// early range check on the high half of the dividend.
module iter_div_prep #(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  input  logic            is_signed,
  input  logic            wide,
  output logic [2*DW-1:0] mag_n,
  output logic [DW-1:0]   mag_d,
  output logic            neg_q,
  output logic            neg_r,
  output logic            pre_ovf
);
  localparam int NW = 2 * DW;

  logic [NW-1:0] ext_n;
  logic          sn, sd;

  always_comb begin
    if (wide)
      ext_n = dividend;
    else if (is_signed)
      ext_n = {{DW{dividend[DW-1]}}, dividend[DW-1:0]};
    else
      ext_n = {{DW{1'b0}}, dividend[DW-1:0]};
    sn      = is_signed & ext_n[NW-1];
    sd      = is_signed & divisor[DW-1];
    mag_n   = sn ? (~ext_n + NW'(1)) : ext_n;
    mag_d   = sd ? (~divisor + DW'(1)) : divisor;
    neg_q   = sn ^ sd;
    neg_r   = sn;
    // a high half not below the divisor (including a zero divisor) cannot
    // give a quotient that fits in DW bits
    pre_ovf = (mag_n[NW-1:DW] >= mag_d);
  end
endmodule

// File: rtl/iter_div_step.sv
// One non-restoring iteration: shift, then add or subtract by sign.
module iter_div_step #(
  parameter int DW = 16
) (
  input  logic [DW+1:0] p_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] d_in,
  output logic [DW+1:0] p_out,
  output logic [DW-1:0] a_out
);
  localparam int PW = DW + 2;

  logic [PW-1:0] shifted;
  logic [PW-1:0] dx;

  always_comb begin
    shifted = {p_in[PW-2:0], a_in[DW-1]};
    dx      = {2'b00, d_in};
    p_out   = p_in[PW-1] ? (shifted + dx) : (shifted - dx);
    a_out   = {a_in[DW-2:0], ~p_out[PW-1]};
  end
endmodule

// File: rtl/iter_div_fix.sv
// Sign application and signed range check on the magnitude results.
module iter_div_fix #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] q_mag,
  input  logic [DW-1:0] r_mag,
  input  logic          neg_q,
  input  logic          neg_r,
  input  logic          is_signed,
  input  logic          pre_ovf,
  output logic [DW-1:0] q_out,
  output logic [DW-1:0] r_out,
  output logic          ovf_out
);
  logic sig_ovf;

  always_comb begin
    q_out   = neg_q ? (~q_mag + DW'(1)) : q_mag;
    r_out   = neg_r ? (~r_mag + DW'(1)) : r_mag;
    // a signed magnitude with the top bit set fits only as the most negative value
    sig_ovf = is_signed & q_mag[DW-1] & ~(neg_q & (q_mag[DW-2:0] == '0));
    ovf_out = pre_ovf | sig_ovf;
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stall,
  input  logic            is_signed,
  input  logic            wide,
  input  logic [2*DW-1:0] dividend,
  input  logic [DW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic            ovf,
  output logic [DW-1:0]   quotient,
  output logic [DW-1:0]   remainder
);
  import iter_div_pkg::*;

  localparam int NW = 2 * DW;
  localparam int PW = DW + 2;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

  div_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] p_q, p_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] d_q, d_d;
  logic          negq_q, negq_d, negr_q, negr_d;
  logic          sgn_q, sgn_d, povf_q, povf_d, ovf_q, ovf_d;
  logic          advance;

  logic [NW-1:0] mag_n;
  logic [DW-1:0] mag_d;
  logic          prep_negq, prep_negr, prep_povf;
  logic [PW-1:0] step_p;
  logic [DW-1:0] step_a;
  logic [DW-1:0] fix_q, fix_r;
  logic          fix_ovf;

  iter_div_prep #(.DW(DW)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .is_signed(is_signed),
    .wide     (wide),
    .mag_n    (mag_n),
    .mag_d    (mag_d),
    .neg_q    (prep_negq),
    .neg_r    (prep_negr),
    .pre_ovf  (prep_povf)
  );

  iter_div_step #(.DW(DW)) u_step (
    .p_in (p_q),
    .a_in (a_q),
    .d_in (d_q),
    .p_out(step_p),
    .a_out(step_a)
  );

  iter_div_fix #(.DW(DW)) u_fix (
    .q_mag    (a_q),
    .r_mag    (p_q[DW-1:0]),
    .neg_q    (negq_q),
    .neg_r    (negr_q),
    .is_signed(sgn_q),
    .pre_ovf  (povf_q),
    .q_out    (fix_q),
    .r_out    (fix_r),
    .ovf_out  (fix_ovf)
  );

  assign advance = ~stall;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    p_d     = p_q;
    a_d     = a_q;
    d_d     = d_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    sgn_d   = sgn_q;
    povf_d  = povf_q;
    ovf_d   = ovf_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          p_d     = {2'b00, mag_n[NW-1:DW]};
          a_d     = mag_n[DW-1:0];
          d_d     = mag_d;
          negq_d  = prep_negq;
          negr_d  = prep_negr;
          sgn_d   = is_signed;
          povf_d  = prep_povf;
          cnt_d   = '0;
          phase_d = PH_STEP;
        end
      end
      PH_STEP: begin
        p_d   = step_p;
        a_d   = step_a;
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == LAST_STEP) phase_d = PH_CORR;
      end
      PH_CORR: begin
        if (p_q[PW-1]) p_d = p_q + {2'b00, d_q};
        phase_d = PH_FIX;
      end
      PH_FIX: begin
        a_d     = fix_q;
        p_d     = {2'b00, fix_r};
        ovf_d   = fix_ovf;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      p_q     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      sgn_q   <= 1'b0;
      povf_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (advance) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      p_q     <= p_d;
      a_q     <= a_d;
      d_q     <= d_d;
      negq_q  <= negq_d;
      negr_q  <= negr_d;
      sgn_q   <= sgn_d;
      povf_q  <= povf_d;
      ovf_q   <= ovf_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign done      = (phase_q == PH_FIX) & ~stall;
  assign quotient  = (phase_q == PH_FIX) ? fix_q   : a_q;
  assign remainder = (phase_q == PH_FIX) ? fix_r   : p_q[DW-1:0];
  assign ovf       = (phase_q == PH_FIX) ? fix_ovf : ovf_q;

  // assertions
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !stall) |=> (busy && phase_q == PH_STEP && cnt_q == '0)); // R1

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIX && !povf_q) |-> (!p_q[PW-1] && (p_q < {2'b00, d_q}))); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(phase_q) && $stable(cnt_q) && $stable(p_q) && $stable(a_q))); // R5

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STEP && start && !stall && cnt_q != LAST_STEP)
      |=> (phase_q == PH_STEP && cnt_q == $past(cnt_q) + CW'(1))); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && !stall))
      |=> ($stable(quotient) && $stable(remainder) && $stable(ovf))); // R8
endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stall = 1'b0;
  logic        is_signed = 1'b0;
  logic        wide = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, ovf;
  logic [15:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  iter_divider u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
    .is_signed(is_signed), .wide(wide), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .ovf(ovf), .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one divide with random stalls; optionally raise start mid-run
  task automatic do_div(input bit sg, input bit wd, input logic [31:0] n,
                        input logic [15:0] d, input int stall_pct, input bit poke);
    longint nv, dv, qe, re;
    bit     oe;
    int     active;
    bit     got_done;
    logic [15:0] q_seen, r_seen;
    logic        o_seen;
    if (wd) nv = sg ? longint'($signed(n)) : longint'(n);
    else    nv = sg ? longint'($signed(n[15:0])) : longint'(n[15:0]);
    dv = sg ? longint'($signed(d)) : longint'(d);
    qe = 0; re = 0;
    if (dv == 0) oe = 1'b1;
    else begin
      qe = nv / dv;
      re = nv % dv;
      oe = sg ? (qe > 32767 || qe < -32768) : (qe > 65535);
    end
    @(negedge clk);
    is_signed = sg; wide = wd; dividend = n; divisor = d;
    start = 1'b1; stall = 1'b0;
    active = 1;
    got_done = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start = poke && (k == 2);
      if (poke && k == 2) begin dividend = ~n; divisor = d + 16'd3; end
      stall = (($urandom % 100) < stall_pct);
      #1;
      if (stall) check(!done, "R5 done while stalled", done, 0);
      if (!stall) active++;
      if (done) begin got_done = 1'b1; break; end
    end
    check(got_done && active == 19, "R4 active cycles", active, 19);
    check(ovf == oe, "R6 overflow flag", ovf, oe);
    if (!oe) begin
      if (sg) begin
        check(quotient == qe[15:0], poke ? "R7 quotient" : "R3 quotient", quotient, qe[15:0]);
        check(remainder == re[15:0], "R3 remainder", remainder, re[15:0]);
      end else begin
        check(quotient == qe[15:0], poke ? "R7 quotient" : "R2 quotient", quotient, qe[15:0]);
        check(remainder == re[15:0], "R2 remainder", remainder, re[15:0]);
      end
    end
    q_seen = quotient; r_seen = remainder; o_seen = ovf;
    @(negedge clk);
    start = 1'b0; stall = 1'b0; dividend = 32'h1234_5678; divisor = 16'h0011;
    #1;
    check(!busy && !done, "R8 idle after done", {busy, done}, 0);
    check(quotient == q_seen && remainder == r_seen && ovf == o_seen,
          "R8 results held", {quotient, remainder, ovf}, {q_seen, r_seen, o_seen});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !ovf, "R9 in reset", {busy, done, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!busy && !done && !ovf, "R9 after reset", {busy, done, ovf}, 0);
    // a stalled start is not accepted (R1)
    @(negedge clk); start = 1'b1; stall = 1'b1; dividend = 32'd9; divisor = 16'd2;
    @(negedge clk); start = 1'b0; stall = 1'b0; #1;
    check(!busy, "R1 stalled start refused", busy, 0);

    // directed corners
    do_div(1'b0, 1'b1, 32'd100, 16'd7, 0, 1'b0);                 // R2
    do_div(1'b0, 1'b1, 32'hFFFF_FFFF, 16'hFFFF, 0, 1'b0);        // R6 quotient 65537
    do_div(1'b0, 1'b1, 32'hFFFE_FFFF, 16'hFFFF, 30, 1'b0);       // R2 max fitting
    do_div(1'b0, 1'b0, 32'hABCD_FFFF, 16'h0001, 0, 1'b0);        // R2 narrow ignores high half
    do_div(1'b0, 1'b1, 32'd5, 16'd0, 0, 1'b0);                   // R6 zero divisor
    do_div(1'b1, 1'b1, -32'sd7, 16'd2, 0, 1'b0);                 // R3 -3 r -1
    do_div(1'b1, 1'b1, 32'd7, -16'sd2, 20, 1'b0);                // R3 -3 r 1
    do_div(1'b1, 1'b0, 32'h0000_8000, 16'hFFFF, 0, 1'b0);        // R6 -32768/-1
    do_div(1'b1, 1'b0, 32'h0000_8000, 16'h0001, 0, 1'b0);        // R3 -32768/1
    do_div(1'b1, 1'b1, 32'h8000_0000, 16'hFFFF, 0, 1'b0);        // R6
    do_div(1'b1, 1'b1, 32'hFFFF_8000, 16'h0001, 0, 1'b0);        // R3
    do_div(1'b1, 1'b1, 32'h0000_8000, 16'h0001, 0, 1'b0);        // R6 +32768
    do_div(1'b1, 1'b1, 32'h0012_3456, 16'h8000, 60, 1'b0);       // R3
    do_div(1'b0, 1'b1, 32'h0001_0203, 16'h0405, 40, 1'b1);       // R7
    do_div(1'b1, 1'b1, -32'sd70000, 16'd3, 80, 1'b1);            // R7 heavy stall

    // broad sweep across modes, magnitudes and stall densities
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] n;
      logic [15:0] d;
      bit sg, wd;
      int sh;
      sg = i[0];
      wd = (i % 4) < 3;
      sh = int'($urandom % 21);
      n  = $urandom;
      n  = sg ? 32'($signed(n) >>> sh) : (n >> sh);
      d  = 16'($urandom);
      if ((i % 7) == 0) d = d >> ($urandom % 16);
      if ((i % 97) == 0) d = 16'd0;
      do_div(sg, wd, n, d, int'($urandom % 50), (i % 50) == 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule